// File: doc/BRIEF.md
# Range-Rule Fanout Distributor

This block turns one spike, identified by the address of the neuron that fired, into a stream of per-neuron update requests for a bank of parallel compute cores. Spikes wait in an upstream queue keyed by their source address. The destination neurons are worked out only when a spike is taken in here. The lookup uses a small table of connection rules. Each rule maps a contiguous range of source addresses onto a contiguous range of destination addresses. This lets a whole all-to-all layer projection be held in one entry instead of one entry per synapse.

When a spike is accepted, the block scans every rule slot in index order. It expands every rule whose source range holds the spike address. Each expanded destination range is walked in windows that match the core count and are aligned to it. Every destination in a window goes to the core whose number equals the low address bits of that destination. The request carries the destination address and the spike's source address, and the core uses both for its weight lookup.

A window is only released after every core in it has signalled completion. This gives a barrier between windows, and a core never holds two requests at the same time. Weights, membrane state and spike generation belong to other blocks.

Top module: `fanout_distributor`

## Requirements
- R1: The rule table holds 16 slots, each with a valid flag, a source low/high bound and a destination low/high bound (32-bit addresses). A write with `rule_we` high stores all five fields into slot `rule_waddr` at the clock edge. Writing `rule_wvalid` low disables the slot, and a disabled slot never produces requests.
- R2: A valid rule matches when src_lo <= source <= src_hi, with both bounds inclusive. A rule whose destination high bound is below its destination low bound produces no requests.
- R3: Every matching rule is expanded, in ascending slot order. Each rule's destinations are issued in ascending address order.
- R4: A destination is sent to core number `dst[4:0]`. While `core_req[k]` is high, `core_dst` lane k holds the destination and `core_src` holds the spike's source address.
- R5: Destinations are grouped into 32-address windows aligned to multiples of 32. No request of a new window is raised until all requests of the previous window have completed. Windows at the very top of the address space end without wrapping to zero.
- R6: In a window only partly covered by the destination range (first or last), requests are raised only for cores whose address lies within the range.
- R7: A spike matching no valid rule produces no request and the block returns to idle. No request is ever raised while idle.
- R8: `spk_ready` and `idle` are high only when the block has no spike in progress, and a spike is accepted when `spk_valid` and `spk_ready` are both high at a clock edge. A request stays high until the clock edge at which its core returns `core_done` high.
- R9: After reset the block is idle, all requests are low and every rule slot is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rule_we | input | 1 | Rule slot write strobe |
| rule_waddr | input | 4 | Rule slot index |
| rule_wvalid | input | 1 | Valid flag written to the slot |
| rule_src_lo | input | 32 | Source range low bound |
| rule_src_hi | input | 32 | Source range high bound |
| rule_dst_lo | input | 32 | Destination range low bound |
| rule_dst_hi | input | 32 | Destination range high bound |
| spk_valid | input | 1 | Spike offered |
| spk_ready | output | 1 | Block can take a spike |
| spk_src | input | 32 | Source neuron address of the spike |
| core_req | output | 32 | Per-core update request |
| core_dst | output | 1024 | Per-core destination address, lane k at bits 32k+31..32k |
| core_src | output | 32 | Source address shared by all requests |
| core_done | input | 32 | Per-core completion, one per request |
| idle | output | 1 | No spike in progress |

## Verification
A corrupted slot index or window pointer shows at the ports as a wrong destination address, a missing address or a duplicated address. The bench sees it on the first request of the affected window, which is at most one window after the fault. A lost pending bit either releases the next window while a core is still busy or leaves the block stuck out of idle. The first is visible on the cycle the early request rises. The second is visible when `idle` fails to return within a bounded wait. A faulty match compare shows up as extra or missing addresses, and the bench finds them by comparing the full ordered dispatch list of each spike against a model of the table.

// File: rtl/fanout_distributor.sv
module fanout_distributor #(
  parameter int ADDR_W  = 32,
  parameter int N_CORES = 32,
  parameter int N_RULES = 16,
  localparam int CB = $clog2(N_CORES),
  localparam int RB = $clog2(N_RULES)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        rule_we,
  input  logic [RB-1:0]               rule_waddr,
  input  logic                        rule_wvalid,
  input  logic [ADDR_W-1:0]           rule_src_lo,
  input  logic [ADDR_W-1:0]           rule_src_hi,
  input  logic [ADDR_W-1:0]           rule_dst_lo,
  input  logic [ADDR_W-1:0]           rule_dst_hi,
  input  logic                        spk_valid,
  output logic                        spk_ready,
  input  logic [ADDR_W-1:0]           spk_src,
  output logic [N_CORES-1:0]          core_req,
  output logic [N_CORES*ADDR_W-1:0]   core_dst,
  output logic [ADDR_W-1:0]           core_src,
  input  logic [N_CORES-1:0]          core_done,
  output logic                        idle
);

  typedef enum logic [1:0] {S_IDLE, S_SCAN, S_LOAD, S_WAIT} st_t;

  st_t               st;
  logic              rv  [N_RULES];
  logic [ADDR_W-1:0] rsl [N_RULES];
  logic [ADDR_W-1:0] rsh [N_RULES];
  logic [ADDR_W-1:0] rdl [N_RULES];
  logic [ADDR_W-1:0] rdh [N_RULES];

  logic [ADDR_W-1:0]  src_q, cur, last;
  logic [RB-1:0]      ridx;
  logic [N_CORES-1:0] pending, mask, pend_left;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N_RULES; i++) begin
        rv[i]  <= 1'b0;
        rsl[i] <= '0;
        rsh[i] <= '0;
        rdl[i] <= '0;
        rdh[i] <= '0;
      end
    end else if (rule_we) begin
      rv[rule_waddr]  <= rule_wvalid;
      rsl[rule_waddr] <= rule_src_lo;
      rsh[rule_waddr] <= rule_src_hi;
      rdl[rule_waddr] <= rule_dst_lo;
      rdh[rule_waddr] <= rule_dst_hi;
    end
  end

  wire [ADDR_W-1:0] base       = {cur[ADDR_W-1:CB], {CB{1'b0}}};
  wire              last_batch = (base[ADDR_W-1:CB] == last[ADDR_W-1:CB]);
  wire              last_rule  = (ridx == RB'(N_RULES - 1));
  wire              hit        = rv[ridx] && (src_q >= rsl[ridx]) && (src_q <= rsh[ridx])
                                 && (rdl[ridx] <= rdh[ridx]);

  for (genvar k = 0; k < N_CORES; k++) begin : g_lane
    wire [ADDR_W-1:0] slot = {base[ADDR_W-1:CB], CB'(k)};
    assign mask[k] = (slot >= cur) && (slot <= last);
    assign core_dst[k*ADDR_W +: ADDR_W] = slot;
  end

  assign pend_left = pending & ~core_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      src_q   <= '0;
      ridx    <= '0;
      cur     <= '0;
      last    <= '0;
      pending <= '0;
    end else begin
      case (st)
        S_IDLE: if (spk_valid) begin
          src_q <= spk_src;
          ridx  <= '0;
          st    <= S_SCAN;
        end
        S_SCAN: begin
          if (hit) begin
            cur  <= rdl[ridx];
            last <= rdh[ridx];
            st   <= S_LOAD;
          end else if (last_rule) begin
            st <= S_IDLE;
          end else begin
            ridx <= ridx + 1'b1;
          end
        end
        S_LOAD: begin
          pending <= mask;
          st      <= S_WAIT;
        end
        default: begin
          pending <= pend_left;
          if (pend_left == '0) begin
            if (!last_batch) begin
              cur <= base + ADDR_W'(N_CORES);
              st  <= S_LOAD;
            end else if (last_rule) begin
              st <= S_IDLE;
            end else begin
              ridx <= ridx + 1'b1;
              st   <= S_SCAN;
            end
          end
        end
      endcase
    end
  end

  assign core_req  = pending;
  assign core_src  = src_q;
  assign spk_ready = (st == S_IDLE);
  assign idle      = (st == S_IDLE);

endmodule

// File: rtl/fanout_distributor_chk.sv
module fanout_distributor_chk #(
  parameter int ADDR_W  = 32,
  parameter int N_CORES = 32,
  localparam int CB = $clog2(N_CORES)
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      spk_valid,
  input logic                      spk_ready,
  input logic [N_CORES-1:0]        core_req,
  input logic [N_CORES*ADDR_W-1:0] core_dst,
  input logic [N_CORES-1:0]        core_done,
  input logic                      idle
);

  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> core_req == '0);

  p_accept_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (spk_valid && spk_ready) |=> !idle);

  p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(core_req) & ~$past(core_done) & ~core_req) == '0));

  p_barrier_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((core_req & ~$past(core_req)) != '0) |-> ($past(core_req) == '0));

  for (genvar k = 0; k < N_CORES; k++) begin : g_stripe
    p_stripe_r4: assert property (@(posedge clk) disable iff (!rst_n)
      core_req[k] |-> core_dst[k*ADDR_W +: CB] == CB'(k));
  end

endmodule

bind fanout_distributor fanout_distributor_chk #(.ADDR_W(ADDR_W), .N_CORES(N_CORES)) u_chk (.*);

// File: tb/tb_fanout_distributor.sv
`timescale 1ns/1ps
module tb_fanout_distributor;
  localparam int AW = 32;
  localparam int NC = 32;
  localparam int NR = 16;
  localparam int EMAX = 8192;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rule_we = 1'b0;
  logic [3:0] rule_waddr = '0;
  logic rule_wvalid = 1'b0;
  logic [AW-1:0] rule_src_lo = '0, rule_src_hi = '0, rule_dst_lo = '0, rule_dst_hi = '0;
  logic spk_valid = 1'b0;
  logic spk_ready;
  logic [AW-1:0] spk_src = '0;
  logic [NC-1:0] core_req;
  logic [NC*AW-1:0] core_dst;
  logic [AW-1:0] core_src;
  logic [NC-1:0] core_done = '0;
  logic idle;

  always #4 clk = ~clk;

  fanout_distributor dut (
    .clk(clk), .rst_n(rst_n),
    .rule_we(rule_we), .rule_waddr(rule_waddr), .rule_wvalid(rule_wvalid),
    .rule_src_lo(rule_src_lo), .rule_src_hi(rule_src_hi),
    .rule_dst_lo(rule_dst_lo), .rule_dst_hi(rule_dst_hi),
    .spk_valid(spk_valid), .spk_ready(spk_ready), .spk_src(spk_src),
    .core_req(core_req), .core_dst(core_dst), .core_src(core_src),
    .core_done(core_done), .idle(idle)
  );

  int n_chk = 0, n_bad = 0;
  bit m_v [NR];
  logic [AW-1:0] m_sl [NR], m_sh [NR], m_dl [NR], m_dh [NR];
  logic [AW-1:0] expd [EMAX];
  int n_exp;
  logic [AW-1:0] log_dst [EMAX], log_src [EMAX];
  int log_core [EMAX];
  int n_log = 0;
  bit served [NC];
  int cnt [NC];

  task automatic chk(input bit ok, input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=1 expected=0");
    summary();
  end

  // core model: logs requests, answers after a random delay, checks R8 hold
  initial begin
    for (int k = 0; k < NC; k++) begin served[k] = 0; cnt[k] = 0; end
    forever begin
      @(negedge clk);
      for (int k = 0; k < NC; k++) begin
        if (!core_req[k]) begin
          if (served[k] && !core_done[k]) chk(0, "R8 request dropped before done", 0, 1);
          served[k] = 0;
          core_done[k] = 1'b0;
        end else if (!served[k]) begin
          if (n_log < EMAX) begin
            log_dst[n_log] = core_dst[k*AW +: AW];
            log_src[n_log] = core_src;
            log_core[n_log] = k;
            n_log++;
          end
          served[k] = 1;
          cnt[k] = int'($urandom % 4);
        end else if (!core_done[k]) begin
          if (cnt[k] == 0) core_done[k] = 1'b1;
          else cnt[k]--;
        end
      end
    end
  end

  task automatic wr_rule(input int idx, input bit v, input logic [AW-1:0] sl, sh, dl, dh);
    @(negedge clk);
    rule_we = 1'b1; rule_waddr = 4'(idx); rule_wvalid = v;
    rule_src_lo = sl; rule_src_hi = sh; rule_dst_lo = dl; rule_dst_hi = dh;
    m_v[idx] = v; m_sl[idx] = sl; m_sh[idx] = sh; m_dl[idx] = dl; m_dh[idx] = dh;
    @(negedge clk);
    rule_we = 1'b0;
  endtask

  task automatic build_exp(input logic [AW-1:0] s);
    n_exp = 0;
    for (int r = 0; r < NR; r++) begin
      if (m_v[r] && s >= m_sl[r] && s <= m_sh[r] && m_dl[r] <= m_dh[r]) begin
        logic [AW-1:0] a;
        a = m_dl[r];
        forever begin
          if (n_exp < EMAX) expd[n_exp] = a;
          n_exp++;
          if (a == m_dh[r]) break;
          a = a + 1;
        end
      end
    end
  endtask

  task automatic spike(input logic [AW-1:0] s, input string req);
    int w;
    build_exp(s);
    n_log = 0;
    @(negedge clk);
    w = 0;
    while (!spk_ready && w < 5000) begin @(negedge clk); w++; end
    spk_valid = 1'b1; spk_src = s;
    @(negedge clk);
    spk_valid = 1'b0;
    chk(!idle && !spk_ready, "R8 busy after accept", {31'b0, idle}, 0);
    w = 0;
    while (!idle && w < 20000) begin @(negedge clk); w++; end
    chk(idle, "R8 returns to idle", {31'b0, idle}, 1);
    chk(core_req == '0, "R7 no request while idle", core_req, 0);
    chk(n_log == n_exp, {req, " dispatch count"}, n_log, n_exp);
    for (int i = 0; i < n_log && i < n_exp; i++) begin
      chk(log_dst[i] == expd[i], {req, " destination order"}, log_dst[i], expd[i]);
      chk(log_core[i] == int'(log_dst[i][4:0]), "R4 core striping", log_core[i], {27'b0, log_dst[i][4:0]});
      chk(log_src[i] == s, "R4 source carried", log_src[i], s);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int r = 0; r < NR; r++) begin
      m_v[r] = 0; m_sl[r] = '0; m_sh[r] = '0; m_dl[r] = '0; m_dh[r] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(idle && spk_ready, "R9 idle after reset", {31'b0, idle}, 1);
    chk(core_req == '0, "R9 no request after reset", core_req, 0);
    spike(32'd5, "R9 empty table");

    wr_rule(0, 1, 0, 99, 1000, 1070);
    wr_rule(1, 1, 50, 60, 2048, 2111);
    wr_rule(2, 0, 0, 1000, 5000, 5010);
    wr_rule(3, 1, 99, 99, 1025, 1025);
    wr_rule(4, 1, 300, 300, 10, 5);
    wr_rule(5, 1, 400, 400, 32'hFFFF_FFF0, 32'hFFFF_FFFF);
    spike(32'd55, "R3 two rules");
    spike(32'd50, "R2 low bound");
    spike(32'd60, "R2 high bound");
    spike(32'd49, "R6 partial windows");
    spike(32'd99, "R4 single dest 1025");
    spike(32'd100, "R7 no match");
    spike(32'd300, "R2 inverted dest");
    spike(32'd400, "R5 top of space");
    wr_rule(2, 1, 0, 1000, 5000, 5010);
    spike(32'd200, "R1 enabled slot");
    wr_rule(2, 0, 0, 1000, 5000, 5010);
    spike(32'd200, "R1 disabled slot");

    for (int it = 0; it < 24; it++) begin
      for (int r = 0; r < NR; r++) begin
        if ($urandom % 3 == 0) begin
          logic [AW-1:0] sl, dl;
          sl = $urandom % 400;
          dl = $urandom % 4000;
          wr_rule(r, ($urandom % 4) != 0, sl, sl + ($urandom % 80), dl, dl + ($urandom % 100));
        end
      end
      spike($urandom % 480, "R3 random");
    end
    summary();
  end
endmodule